// File: doc/BRIEF.md
# I2C Clock Stretch Injector

This block sits on an I2C bus next to the real devices and watches SCL and SDA. Each time the master runs a transaction, the block counts the SCL pulses and measures how long the transaction lasts, in microseconds. When stretching is armed, it pulls SCL low right after one chosen clock pulse. A master that honours clock stretching must then wait. This exercises the master's stretch handling and timing margins.

Three inputs control the behaviour. The transactions-left count arms the block. The pulse index selects the clock pulse to delay, counting from 1 for the first pulse after START. The stretch length is given in microseconds. A register file outside this block holds the count. Every armed transaction raises a one-cycle decrement request when it ends, and the register file uses it to lower the count. The microsecond time base comes from a divider of the system clock.

Top module: `i2c_stretch_injector`

## Requirements
- R1: After reset, `scl_pull_low`, `meas_valid` and `enable_dec` are 0, and `meas_pulses` and `meas_us` are 0.
- R2: A transaction opens at a START (SDA falls while SCL is high) and closes at a STOP (SDA rises while SCL is high). A repeated START inside it resets nothing. At the STOP, `meas_pulses` takes the number of SCL rising edges seen since the opening START, including the rising edge of the STOP itself, and `meas_valid` is high for exactly one cycle.
- R3: The pulse count saturates at 2^PULSE_W-1 and does not wrap.
- R4: Let D be the number of system clock cycles from the SDA fall of the opening START to the SDA rise of the STOP. `meas_us` then reports floor((D-1)/CLK_PER_US).
- R5: The duration saturates at 2^DUR_W-1 and does not wrap.
- R6: Stretching needs `en_count` nonzero at the opening START, with `cfg_pulse` and `cfg_us` both nonzero. When these hold, `scl_pull_low` rises on the SCL falling edge that follows rising edge number `cfg_pulse`-1, or on the START's own SCL fall when `cfg_pulse` is 1. It then stays high for exactly `cfg_us`*CLK_PER_US cycles. This happens at most once per transaction.
- R7: No stretch occurs if `en_count` was 0 at the opening START, if `cfg_us` is 0, if `cfg_pulse` is 0, or if the selected pulse is never followed by an SCL fall.
- R8: At the STOP of a transaction opened while `en_count` was nonzero, `enable_dec` is high for exactly one cycle, in the same cycle as `meas_valid`. This holds whether or not the stretch happened. Otherwise `enable_dec` stays 0.
- R9: A STOP seen outside a transaction is ignored: no `meas_valid` and no `enable_dec`, and the results do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level on the bus (asynchronous) |
| sda_in | input | 1 | SDA level on the bus (asynchronous) |
| en_count | input | ENA_W | Transactions still to stretch |
| cfg_pulse | input | PULSE_W | 1-based index of the pulse to delay |
| cfg_us | input | US_W | Stretch length in microseconds |
| scl_pull_low | output | 1 | Drive SCL low (open drain) |
| meas_pulses | output | PULSE_W | SCL pulses of last transaction |
| meas_us | output | DUR_W | Duration of last transaction in microseconds |
| meas_valid | output | 1 | One-cycle pulse when results update |
| enable_dec | output | 1 | One-cycle request to decrement the count |

## Verification
The hardest case to reach is a stretch, because it feeds back into the stimulus. While the block holds SCL low, the master must stall, and both the pulse count and the duration have to reflect that stall. The bench therefore models the bus as a wired AND. Its master waits for the real bus SCL to go high before it continues. The bench records where each pull-low begins relative to the SCL rises it counted itself, and how long the pull-low lasts. Randomised pulse indices that land past the end of the transaction, a STOP sent with no transaction open, and one long transaction that saturates both counters under narrowed widths cover the remaining corners.

// File: rtl/i2c_si_pkg.sv
package i2c_si_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/i2c_si_tick.sv
module i2c_si_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  logic [DW-1:0] div_q;

  assign tick = (div_q == DW'(CLK_PER_US - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/i2c_si_events.sv
module i2c_si_events
  import i2c_si_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);
  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_in};
      sda_s <= {sda_s[0], sda_in};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end
  end

  always_comb begin
    ev.rise  = scl_s[1] & ~scl_q;
    ev.fall  = ~scl_s[1] & scl_q;
    ev.start = scl_s[1] & scl_q & sda_q & ~sda_s[1];
    ev.stop  = scl_s[1] & scl_q & ~sda_q & sda_s[1];
  end
endmodule

// File: rtl/i2c_si_meter.sv
module i2c_si_meter
  import i2c_si_pkg::*;
#(
  parameter int PULSE_W = 16,
  parameter int DUR_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  bus_ev_t            ev,
  input  logic               tick,
  input  logic               armed_in,
  output logic               open_start,
  output logic               in_txn,
  output logic               armed,
  output logic [PULSE_W-1:0] pulse_cnt,
  output logic [PULSE_W-1:0] meas_pulses,
  output logic [DUR_W-1:0]   meas_us,
  output logic               meas_valid,
  output logic               enable_dec
);
  localparam logic [PULSE_W-1:0] P_MAX = '1;
  localparam logic [DUR_W-1:0]   D_MAX = '1;
  logic [DUR_W-1:0] us_cnt;

  assign open_start = ev.start & ~in_txn;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_txn      <= 1'b0;
      armed       <= 1'b0;
      pulse_cnt   <= '0;
      us_cnt      <= '0;
      meas_pulses <= '0;
      meas_us     <= '0;
      meas_valid  <= 1'b0;
      enable_dec  <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      enable_dec <= 1'b0;
      if (open_start) begin
        in_txn    <= 1'b1;
        armed     <= armed_in;
        pulse_cnt <= '0;
        us_cnt    <= '0;
      end else if (ev.stop && in_txn) begin
        in_txn      <= 1'b0;
        armed       <= 1'b0;
        meas_pulses <= pulse_cnt;
        meas_us     <= us_cnt;
        meas_valid  <= 1'b1;
        enable_dec  <= armed;
      end else if (in_txn) begin
        if (ev.rise && pulse_cnt != P_MAX) pulse_cnt <= pulse_cnt + 1'b1;
        if (tick && us_cnt != D_MAX)       us_cnt    <= us_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_si_stretch.sv
module i2c_si_stretch
  import i2c_si_pkg::*;
#(
  parameter int PULSE_W    = 16,
  parameter int US_W       = 16,
  parameter int CLK_PER_US = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  bus_ev_t            ev,
  input  logic               in_txn,
  input  logic               armed,
  input  logic [PULSE_W-1:0] pulse_cnt,
  input  logic [PULSE_W-1:0] cfg_pulse,
  input  logic [US_W-1:0]    cfg_us,
  output logic               pull
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  logic [CW-1:0]   cyc_q;
  logic [US_W-1:0] us_q, len_q;
  logic            hit;

  assign hit = in_txn && armed && ev.fall && !pull &&
               cfg_us != '0 && cfg_pulse != '0 &&
               pulse_cnt == cfg_pulse - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull  <= 1'b0;
      cyc_q <= '0;
      us_q  <= '0;
      len_q <= '0;
    end else if (hit) begin
      pull  <= 1'b1;
      cyc_q <= '0;
      us_q  <= '0;
      len_q <= cfg_us;
    end else if (pull) begin
      if (cyc_q == CW'(CLK_PER_US - 1)) begin
        cyc_q <= '0;
        if (us_q == len_q - 1'b1) pull <= 1'b0;
        else                      us_q <= us_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_injector.sv
module i2c_stretch_injector
  import i2c_si_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int ENA_W      = 16,
  parameter int PULSE_W    = 16,
  parameter int US_W       = 16,
  parameter int DUR_W      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [ENA_W-1:0]   en_count,
  input  logic [PULSE_W-1:0] cfg_pulse,
  input  logic [US_W-1:0]    cfg_us,
  output logic               scl_pull_low,
  output logic [PULSE_W-1:0] meas_pulses,
  output logic [DUR_W-1:0]   meas_us,
  output logic               meas_valid,
  output logic               enable_dec
);
  bus_ev_t            ev;
  logic               tick, open_start, in_txn, armed;
  logic [PULSE_W-1:0] pulse_cnt;

  i2c_si_events u_ev (.clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev));

  i2c_si_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clear(open_start), .tick(tick));

  i2c_si_meter #(.PULSE_W(PULSE_W), .DUR_W(DUR_W)) u_meter (
    .clk(clk), .rst(rst), .ev(ev), .tick(tick), .armed_in(en_count != '0),
    .open_start(open_start), .in_txn(in_txn), .armed(armed), .pulse_cnt(pulse_cnt),
    .meas_pulses(meas_pulses), .meas_us(meas_us), .meas_valid(meas_valid),
    .enable_dec(enable_dec));

  i2c_si_stretch #(.PULSE_W(PULSE_W), .US_W(US_W), .CLK_PER_US(CLK_PER_US)) u_str (
    .clk(clk), .rst(rst), .ev(ev), .in_txn(in_txn), .armed(armed),
    .pulse_cnt(pulse_cnt), .cfg_pulse(cfg_pulse), .cfg_us(cfg_us), .pull(scl_pull_low));
endmodule

// File: rtl/i2c_stretch_injector_chk.sv
module i2c_stretch_injector_chk #(
  parameter int PULSE_W = 16,
  parameter int DUR_W   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_pull_low,
  input logic               meas_valid,
  input logic               enable_dec,
  input logic [PULSE_W-1:0] meas_pulses,
  input logic [DUR_W-1:0]   meas_us
);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> !meas_valid);
  p_results_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |-> ($stable(meas_pulses) && $stable(meas_us)));
  p_dec_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    enable_dec |-> meas_valid);
  p_no_dec_in_stretch_r8: assert property (@(posedge clk) disable iff (rst)
    scl_pull_low |-> !enable_dec);
  p_stretch_min_len_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull_low) |=> scl_pull_low);
endmodule

bind i2c_stretch_injector i2c_stretch_injector_chk #(.PULSE_W(PULSE_W), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_pull_low(scl_pull_low), .meas_valid(meas_valid),
  .enable_dec(enable_dec), .meas_pulses(meas_pulses), .meas_us(meas_us));

// File: tb/tb_i2c_stretch_injector.sv
`timescale 1ns/1ps
module tb_i2c_stretch_injector;
  localparam int DIV = 4, ENA_W = 4, PW = 5, UW = 8, DW = 8;
  localparam int PMAX = (1 << PW) - 1, DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [ENA_W-1:0] en_count = '0;
  logic [PW-1:0] cfg_pulse = '0;
  logic [UW-1:0] cfg_us = '0;
  logic scl_pull_low, meas_valid, enable_dec;
  logic [PW-1:0] meas_pulses;
  logic [DW-1:0] meas_us;
  wire scl_bus = scl_m & ~scl_pull_low;

  always #2 clk = ~clk;

  i2c_stretch_injector #(.CLK_PER_US(DIV), .ENA_W(ENA_W), .PULSE_W(PW), .US_W(UW), .DUR_W(DW)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_m), .en_count(en_count),
    .cfg_pulse(cfg_pulse), .cfg_us(cfg_us), .scl_pull_low(scl_pull_low),
    .meas_pulses(meas_pulses), .meas_us(meas_us), .meas_valid(meas_valid),
    .enable_dec(enable_dec));

  int tests = 0, fails = 0, cyc = 0, hh = 6;
  int rises = 0, runs = 0, run_len = 0, run_pos = 0, nvalid = 0, ndec = 0;
  int got_p = 0, got_u = 0, t_start = 0, t_stop = 0;
  logic prev_bus = 1'b1, prev_pull = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scl_bus && !prev_bus) rises <= rises + 1;
    prev_bus <= scl_bus;
    if (scl_pull_low && !prev_pull) begin runs <= runs + 1; run_pos <= rises; run_len <= 1; end
    else if (scl_pull_low) run_len <= run_len + 1;
    prev_pull <= scl_pull_low;
    if (meas_valid) begin nvalid <= nvalid + 1; got_p <= int'(meas_pulses); got_u <= int'(meas_us); end
    if (enable_dec) ndec <= ndec + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
    wt(hh);
  endtask

  task automatic do_start();
    sda_m = 1'b0; t_start = cyc; wt(hh);
    scl_m = 1'b0; wt(hh);
  endtask

  task automatic do_bit(input logic b);
    sda_m = b; wt(hh);
    scl_up();
    scl_m = 1'b0; wt(hh);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; wt(hh);
    scl_up();
    sda_m = 1'b0; wt(hh);
    scl_m = 1'b0; wt(hh);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(hh);
    scl_up();
    sda_m = 1'b1; t_stop = cyc; wt(hh);
  endtask

  function automatic int exp_dur(input int d);
    int v = (d - 1) / DIV;
    return (v > DMAX) ? DMAX : v;
  endfunction

  task automatic run_txn(input int nbits, input int rs_at, input int en, input int pulse, input int us);
    int r0, total, want;
    en_count = ENA_W'(en); cfg_pulse = PW'(pulse); cfg_us = UW'(us);
    wt(4);
    r0 = rises; runs = 0; nvalid = 0; ndec = 0;
    do_start();
    for (int i = 0; i < nbits; i++) begin
      if (i == rs_at) do_rstart();
      do_bit(1'($urandom_range(0, 1)));
    end
    do_stop();
    wt(6);
    total = rises - r0;
    want = (en != 0 && us != 0 && pulse != 0 && (pulse - 1) < total) ? 1 : 0;
    chk("R2 valid pulses", nvalid, 1);
    chk("R2/R3 pulse count", got_p, (total > PMAX) ? PMAX : total);
    chk("R4/R5 duration", got_u, exp_dur(t_stop - t_start));
    chk("R8 decrement", ndec, (en != 0) ? 1 : 0);
    chk("R6/R7 stretch count", runs, want);
    if (want == 1) begin
      chk("R6 stretch position", run_pos - r0, pulse - 1);
      chk("R6 stretch length", run_len, us * DIV);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    wt(3);
    chk("R1 reset outputs", int'({scl_pull_low, meas_valid, enable_dec, meas_pulses, meas_us}), 0);
    rst = 1'b0;
    wt(4);
    // directed: first pulse, no repeated start
    run_txn(9, -1, 1, 1, 3);
    // repeated start keeps counting
    run_txn(18, 9, 2, 14, 2);
    // disarmed, zero length, zero index, index past end
    run_txn(9, -1, 0, 3, 4);
    run_txn(9, -1, 3, 3, 0);
    run_txn(9, -1, 3, 0, 2);
    run_txn(9, -1, 1, 12, 2);
    // R9 stop with no transaction open
    nvalid = 0; ndec = 0;
    scl_m = 1'b0; wt(hh); sda_m = 1'b0; wt(hh);
    scl_up(); sda_m = 1'b1; wt(hh + 6);
    chk("R9 orphan stop valid", nvalid, 0);
    chk("R9 orphan stop dec", ndec, 0);
    chk("R9 results kept", int'(meas_pulses), 10);
    // R3/R5 saturation in one long transaction
    hh = 8;
    run_txn(48, -1, 1, 5, 2);
    hh = 6;
    // random mix
    for (int t = 0; t < 30; t++) begin
      int nb = $urandom_range(3, 20);
      int rs = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, nb - 1)) : -1;
      run_txn(nb, rs, $urandom_range(0, 2), $urandom_range(0, nb + 4), $urandom_range(0, 4));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule